// File: doc/BRIEF.md
# Integer Execute and Next-PC Unit

This block is the purely combinational heart of a single-issue 32-bit integer core. Each cycle it receives one fixed-length instruction word, the address that word was fetched from, and the two source operands already read from the register file. In the same cycle it produces the value to write back, the write strobe and destination index, and the address of the next instruction. It also produces the effective address and store data for memory operations.

The decode covers register-register and register-immediate arithmetic, logic, shifts and compares, the upper-immediate forms, both jumps and the six conditional branches. Immediates are rebuilt from the scattered bit groups of each format, and the sign always comes from bit 31. A word with an unknown major opcode raises an illegal flag and writes nothing. The register file, the data memory and the fetch stage sit outside the block.

Top module: `rvx_exec`

## Requirements
- R1: `rd_addr_o` always equals instruction bits 11:7. The major opcode is taken from bits 6:0, funct3 from bits 14:12, and the alternate-operation flag from bit 30.
- R2: Major opcode 0110011 (register form) computes rs1 op rs2. funct3 000 is add, or subtract when bit 30 is 1. 001 is shift left. 100 is xor. 101 is logical right shift, or arithmetic right shift when bit 30 is 1. 110 is or, and 111 is and. Shift amounts use only the low 5 bits of rs2.
- R3: Major opcode 0010011 (immediate form) uses the same funct3 map with the sign-extended bits 31:20 as the second operand. Bit 30 selects arithmetic right shift only for funct3 101; an add-immediate with bit 30 set still adds.
- R4: funct3 010 and 011 write 1 when rs1 is below the second operand and 0 otherwise. 010 compares as signed and 011 as unsigned, in both the register and the immediate forms.
- R5: Opcode 0110111 writes {bits 31:12, 12 zero bits}. Opcode 0010111 writes the PC plus that value.
- R6: Opcode 1101111 writes PC+4 and jumps to the PC plus a signed even offset built as {bit31, bits19:12, bit20, bits30:21, 0}.
- R7: Opcode 1100111 writes PC+4 and jumps to rs1 plus the sign-extended bits 31:20, with bit 0 of the target cleared.
- R8: Opcode 1100011 compares rs1 with rs2. funct3 000 tests equal, 001 not equal, 100 signed less, 101 signed greater-or-equal, 110 unsigned less and 111 unsigned greater-or-equal. When the test holds, the next PC is the PC plus {bit31, bit7, bits30:25, bits11:8, 0}, sign-extended. A branch never writes a register.
- R9: A branch that is not taken, a branch with funct3 010 or 011, and every instruction that is not a jump give next PC = PC+4.
- R10: Opcode 0000011 raises `load_o`, and opcode 0100011 raises `store_o`. Both output rs1 plus a sign-extended offset: bits 31:20 for a load, {bits 31:25, bits 11:7} for a store. `store_data_o` is rs2. Neither form asserts `rd_we_o`.
- R11: When bits 11:7 are zero, `rd_we_o` is low for every instruction.
- R12: Any major opcode outside the nine above raises `illegal_o`, keeps `rd_we_o` low and gives next PC = PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | Address of the instruction |
| rs1_val_i | input | 32 | First source operand |
| rs2_val_i | input | 32 | Second source operand |
| rd_addr_o | output | 5 | Destination register index |
| rd_we_o | output | 1 | Destination write strobe |
| rd_wdata_o | output | 32 | Destination write value |
| next_pc_o | output | 32 | Address of the next instruction |
| mem_addr_o | output | 32 | Effective address for a load or store |
| store_data_o | output | 32 | Data for a store |
| load_o | output | 1 | Instruction is a load |
| store_o | output | 1 | Instruction is a store |
| illegal_o | output | 1 | Major opcode not recognised |

## Verification
The unit holds no state, so every output is due in the same cycle its inputs are applied, with zero register latency. The bench changes the instruction, PC and operands on the falling clock edge. It compares all outputs with a behavioural model a short time later, still before the next rising edge, so each comparison sees inputs that have settled. Directed words cover signed extremes, offset sign bits, bit-30 aliasing and x0 destinations. Randomised words then cover every opcode with arbitrary fields.

// File: rtl/rvx_pkg.sv
package rvx_pkg;
  localparam int XLEN    = 32;
  localparam int ILEN    = 32;
  localparam int REG_AW  = 5;
  localparam int SHAMT_W = $clog2(XLEN);
  localparam int PC_STEP = ILEN / 8;

  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_IMM    = 7'b0010011;
  localparam logic [6:0] OPC_REG    = 7'b0110011;

  typedef enum logic [3:0] {
    CL_ILLEGAL, CL_LUI, CL_AUIPC, CL_JAL, CL_JALR,
    CL_BRANCH, CL_LOAD, CL_STORE, CL_ALU_IMM, CL_ALU_REG
  } iclass_e;

  typedef enum logic [2:0] {IMM_I, IMM_S, IMM_B, IMM_U, IMM_J} imm_fmt_e;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
    ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR, ALU_AND
  } alu_op_e;

  typedef struct packed {
    iclass_e  cls;
    imm_fmt_e fmt;
    alu_op_e  alu_op;
    logic     use_imm;
    logic     writes_rd;
  } dec_t;
endpackage

// File: rtl/rvx_decode.sv
module rvx_decode
  import rvx_pkg::*;
(
  input  logic [6:0] opcode_i,
  input  logic [2:0] funct3_i,
  input  logic       alt_i,
  output dec_t       dec_o
);
  alu_op_e arith_op;

  // bit 30 only alters add (register form) and right shifts
  always_comb begin
    case (funct3_i)
      3'b000:  arith_op = (opcode_i == OPC_REG && alt_i) ? ALU_SUB : ALU_ADD;
      3'b001:  arith_op = ALU_SLL;
      3'b010:  arith_op = ALU_SLT;
      3'b011:  arith_op = ALU_SLTU;
      3'b100:  arith_op = ALU_XOR;
      3'b101:  arith_op = alt_i ? ALU_SRA : ALU_SRL;
      3'b110:  arith_op = ALU_OR;
      default: arith_op = ALU_AND;
    endcase
  end

  always_comb begin
    dec_o.cls       = CL_ILLEGAL;
    dec_o.fmt       = IMM_I;
    dec_o.alu_op    = ALU_ADD;
    dec_o.use_imm   = 1'b0;
    dec_o.writes_rd = 1'b0;
    case (opcode_i)
      OPC_LUI:    begin dec_o.cls = CL_LUI;   dec_o.fmt = IMM_U; dec_o.writes_rd = 1'b1; end
      OPC_AUIPC:  begin dec_o.cls = CL_AUIPC; dec_o.fmt = IMM_U; dec_o.writes_rd = 1'b1; end
      OPC_JAL:    begin dec_o.cls = CL_JAL;   dec_o.fmt = IMM_J; dec_o.writes_rd = 1'b1; end
      OPC_JALR:   begin
        dec_o.cls = CL_JALR; dec_o.use_imm = 1'b1; dec_o.writes_rd = 1'b1;
      end
      OPC_BRANCH: begin dec_o.cls = CL_BRANCH; dec_o.fmt = IMM_B; end
      OPC_LOAD:   begin dec_o.cls = CL_LOAD;   dec_o.use_imm = 1'b1; end
      OPC_STORE:  begin dec_o.cls = CL_STORE;  dec_o.fmt = IMM_S; dec_o.use_imm = 1'b1; end
      OPC_IMM:    begin
        dec_o.cls = CL_ALU_IMM; dec_o.use_imm = 1'b1;
        dec_o.writes_rd = 1'b1; dec_o.alu_op = arith_op;
      end
      OPC_REG:    begin
        dec_o.cls = CL_ALU_REG; dec_o.writes_rd = 1'b1; dec_o.alu_op = arith_op;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rvx_imm.sv
module rvx_imm
  import rvx_pkg::*;
(
  input  logic [31:7]     instr_i,
  input  imm_fmt_e        fmt_i,
  output logic [XLEN-1:0] imm_o
);
  logic sgn;
  assign sgn = instr_i[31];

  always_comb begin
    case (fmt_i)
      IMM_S:   imm_o = {{(XLEN-12){sgn}}, instr_i[31:25], instr_i[11:7]};
      IMM_B:   imm_o = {{(XLEN-13){sgn}}, sgn, instr_i[7], instr_i[30:25], instr_i[11:8], 1'b0};
      IMM_U:   imm_o = {instr_i[31:12], 12'b0};
      IMM_J:   imm_o = {{(XLEN-21){sgn}}, sgn, instr_i[19:12], instr_i[20], instr_i[30:21], 1'b0};
      default: imm_o = {{(XLEN-12){sgn}}, instr_i[31:20]};
    endcase
  end
endmodule

// File: rtl/rvx_alu.sv
module rvx_alu
  import rvx_pkg::*;
(
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] y_o
);
  logic [SHAMT_W-1:0] shamt;
  assign shamt = b_i[SHAMT_W-1:0];

  always_comb begin
    case (op_i)
      ALU_SUB:  y_o = a_i - b_i;
      ALU_SLL:  y_o = a_i << shamt;
      ALU_SLT:  y_o = {{(XLEN-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      ALU_SLTU: y_o = {{(XLEN-1){1'b0}}, a_i < b_i};
      ALU_XOR:  y_o = a_i ^ b_i;
      ALU_SRL:  y_o = a_i >> shamt;
      ALU_SRA:  y_o = $unsigned($signed(a_i) >>> shamt);
      ALU_OR:   y_o = a_i | b_i;
      ALU_AND:  y_o = a_i & b_i;
      default:  y_o = a_i + b_i;
    endcase
  end
endmodule

// File: rtl/rvx_branch.sv
module rvx_branch
  import rvx_pkg::*;
(
  input  logic [2:0]      funct3_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            take_o
);
  logic eq, lts, ltu;
  assign eq  = a_i == b_i;
  assign lts = $signed(a_i) < $signed(b_i);
  assign ltu = a_i < b_i;

  always_comb begin
    case (funct3_i)
      3'b000:  take_o = eq;
      3'b001:  take_o = !eq;
      3'b100:  take_o = lts;
      3'b101:  take_o = !lts;
      3'b110:  take_o = ltu;
      3'b111:  take_o = !ltu;
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rvx_exec.sv
module rvx_exec
  import rvx_pkg::*;
(
  input  logic [ILEN-1:0]   instr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   rs1_val_i,
  input  logic [XLEN-1:0]   rs2_val_i,
  output logic [REG_AW-1:0] rd_addr_o,
  output logic              rd_we_o,
  output logic [XLEN-1:0]   rd_wdata_o,
  output logic [XLEN-1:0]   next_pc_o,
  output logic [XLEN-1:0]   mem_addr_o,
  output logic [XLEN-1:0]   store_data_o,
  output logic              load_o,
  output logic              store_o,
  output logic              illegal_o
);
  dec_t            dec;
  logic [XLEN-1:0] imm, alu_b, alu_y, pc_seq, pc_rel;
  logic            take;

  rvx_decode i_decode (
    .opcode_i (instr_i[6:0]),
    .funct3_i (instr_i[14:12]),
    .alt_i    (instr_i[30]),
    .dec_o    (dec)
  );

  rvx_imm i_imm (
    .instr_i (instr_i[31:7]),
    .fmt_i   (dec.fmt),
    .imm_o   (imm)
  );

  assign alu_b = dec.use_imm ? imm : rs2_val_i;

  rvx_alu i_alu (
    .op_i (dec.alu_op),
    .a_i  (rs1_val_i),
    .b_i  (alu_b),
    .y_o  (alu_y)
  );

  rvx_branch i_branch (
    .funct3_i (instr_i[14:12]),
    .a_i      (rs1_val_i),
    .b_i      (rs2_val_i),
    .take_o   (take)
  );

  assign pc_seq = pc_i + XLEN'(PC_STEP);
  assign pc_rel = pc_i + imm;

  assign rd_addr_o    = instr_i[11:7];
  assign rd_we_o      = dec.writes_rd && (rd_addr_o != '0);
  assign illegal_o    = dec.cls == CL_ILLEGAL;
  assign load_o       = dec.cls == CL_LOAD;
  assign store_o      = dec.cls == CL_STORE;
  assign mem_addr_o   = alu_y;
  assign store_data_o = rs2_val_i;

  always_comb begin
    case (dec.cls)
      CL_LUI:          rd_wdata_o = imm;
      CL_AUIPC:        rd_wdata_o = pc_rel;
      CL_JAL, CL_JALR: rd_wdata_o = pc_seq;
      default:         rd_wdata_o = alu_y;
    endcase
  end

  always_comb begin
    case (dec.cls)
      CL_JAL:    next_pc_o = pc_rel;
      CL_JALR:   next_pc_o = {alu_y[XLEN-1:1], 1'b0};
      CL_BRANCH: next_pc_o = take ? pc_rel : pc_seq;
      default:   next_pc_o = pc_seq;
    endcase
  end

  always_comb begin
    // R12
    illegal_no_write_chk: assert (!(illegal_o && rd_we_o))
      else $error("illegal word writes a register");
    // R11
    x0_no_write_chk: assert (!(instr_i[11:7] == 5'd0 && rd_we_o))
      else $error("write to x0");
    // R10
    mem_no_write_chk: assert (!((load_o || store_o) && rd_we_o))
      else $error("memory op writes a register");
    // R8
    branch_no_write_chk: assert (!(instr_i[6:0] == OPC_BRANCH && rd_we_o))
      else $error("branch writes a register");
  end
endmodule

// File: tb/test_rvx_exec.sv
`timescale 1ns/1ps
module test_rvx_exec;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] instr, pc, ra, rb;
  logic [4:0]  rd_addr;
  logic        rd_we, load, store, illegal;
  logic [31:0] rd_wdata, next_pc, mem_addr, store_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  rvx_exec i_rvx_exec (
    .instr_i (instr), .pc_i (pc), .rs1_val_i (ra), .rs2_val_i (rb),
    .rd_addr_o (rd_addr), .rd_we_o (rd_we), .rd_wdata_o (rd_wdata),
    .next_pc_o (next_pc), .mem_addr_o (mem_addr), .store_data_o (store_data),
    .load_o (load), .store_o (store), .illegal_o (illegal)
  );

  function automatic logic [31:0] enc_r(int f7, int rs2, int rs1, int f3, int rd, logic [6:0] op);
    return {7'(f7), 5'(rs2), 5'(rs1), 3'(f3), 5'(rd), op};
  endfunction
  function automatic logic [31:0] enc_i(int imm, int rs1, int f3, int rd, logic [6:0] op);
    return {12'(imm), 5'(rs1), 3'(f3), 5'(rd), op};
  endfunction
  function automatic logic [31:0] enc_s(int imm, int rs2, int rs1, int f3);
    logic [11:0] o = 12'(imm);
    return {o[11:5], 5'(rs2), 5'(rs1), 3'(f3), o[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] enc_b(int off, int rs2, int rs1, int f3);
    logic [12:0] o = 13'(off);
    return {o[12], o[10:5], 5'(rs2), 5'(rs1), 3'(f3), o[4:1], o[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] enc_j(int off, int rd);
    logic [20:0] o = 21'(off);
    return {o[20], o[10:1], o[11], o[19:12], 5'(rd), 7'b1101111};
  endfunction

  function automatic logic [31:0] alu_ref(logic [2:0] f3, bit alt, logic [31:0] x, logic [31:0] y);
    int sh = int'(y[4:0]);
    case (f3)
      3'd0: return alt ? x - y : x + y;
      3'd1: return x << sh;
      3'd2: return (int'(x) < int'(y)) ? 32'd1 : 32'd0;
      3'd3: return (longint'({32'd0, x}) < longint'({32'd0, y})) ? 32'd1 : 32'd0;
      3'd4: return x ^ y;
      3'd5: return alt ? 32'(int'(x) >>> sh) : x >> sh;
      3'd6: return x | y;
      default: return x & y;
    endcase
  endfunction

  task automatic model(input logic [31:0] w, p, a, b,
                       output logic [31:0] wd, np, ad, output bit we, ld, st, ill,
                       output string tag);
    int ii = int'($signed(w[31:20]));
    int si = int'($signed({w[31:25], w[11:7]}));
    int bi = (w[31] ? -4096 : 0) + int'(w[7]) * 2048 + int'(w[30:25]) * 32 + int'(w[11:8]) * 2;
    int ji = (w[31] ? -(1 << 20) : 0) + int'(w[19:12]) * 4096 + int'(w[20]) * 2048
             + int'(w[30:21]) * 2;
    logic [31:0] ui = {w[31:12], 12'h000};
    logic [2:0] f3 = w[14:12];
    bit writes = 1'b0;
    bit take = 1'b0;
    wd = 32'd0; np = p + 32'd4; ad = 32'd0; ld = 1'b0; st = 1'b0; ill = 1'b0;
    case (w[6:0])
      7'h37: begin wd = ui; writes = 1'b1; tag = "R5"; end
      7'h17: begin wd = p + ui; writes = 1'b1; tag = "R5"; end
      7'h6f: begin wd = p + 32'd4; np = p + 32'(ji); writes = 1'b1; tag = "R6"; end
      7'h67: begin
        wd = p + 32'd4; np = (a + 32'(ii)) & ~32'd1; ad = a + 32'(ii); writes = 1'b1; tag = "R7";
      end
      7'h63: begin
        case (f3)
          3'd0: take = a == b;
          3'd1: take = a != b;
          3'd4: take = int'(a) < int'(b);
          3'd5: take = int'(a) >= int'(b);
          3'd6: take = {1'b0, a} < {1'b0, b};
          3'd7: take = {1'b0, a} >= {1'b0, b};
          default: take = 1'b0;
        endcase
        if (take) np = p + 32'(bi);
        tag = take ? "R8" : "R9";
      end
      7'h03: begin ld = 1'b1; ad = a + 32'(ii); tag = "R10"; end
      7'h23: begin st = 1'b1; ad = a + 32'(si); tag = "R10"; end
      7'h13: begin
        wd = alu_ref(f3, (f3 == 3'd5) && w[30], a, 32'(ii)); ad = wd; writes = 1'b1;
        tag = (f3 == 3'd2 || f3 == 3'd3) ? "R4" : "R3";
      end
      7'h33: begin
        wd = alu_ref(f3, (f3 == 3'd0 || f3 == 3'd5) && w[30], a, b); ad = wd; writes = 1'b1;
        tag = (f3 == 3'd2 || f3 == 3'd3) ? "R4" : "R2";
      end
      default: begin ill = 1'b1; tag = "R12"; end
    endcase
    we = writes && (w[11:7] != 5'd0);
    if (writes && w[11:7] == 5'd0) tag = "R11";
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  // drive on the falling edge; outputs are combinational, compare 2 ns later
  task automatic run(logic [31:0] w, p, a, b);
    logic [31:0] wd, np, ad;
    bit we, ld, st, ill;
    string tag;
    @(negedge clk);
    instr = w; pc = p; ra = a; rb = b;
    #2;
    model(w, p, a, b, wd, np, ad, we, ld, st, ill, tag);
    chk("R1", "rd_addr", 32'(rd_addr), 32'(w[11:7]));
    chk(tag, "rd_we", 32'(rd_we), 32'(we));
    if (we) chk(tag, "rd_wdata", rd_wdata, wd);
    chk(tag, "next_pc", next_pc, np);
    chk(tag, "load", 32'(load), 32'(ld));
    chk(tag, "store", 32'(store), 32'(st));
    chk(tag, "illegal", 32'(illegal), 32'(ill));
    if (ld || st) chk("R10", "mem_addr", mem_addr, ad);
    if (st) chk("R10", "store_data", store_data, b);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    instr = 32'd0; pc = 32'd0; ra = 32'd0; rb = 32'd0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // R12 all-zero word after reset
    run(32'd0, 32'h0000_0040, 32'd0, 32'd0);
    chk("R12", "illegal at start", 32'(illegal), 32'd1);
    chk("R12", "next_pc on illegal", next_pc, 32'h0000_0044);
    run(32'hFFFF_FFFF, 32'h100, 32'd1, 32'd2);
    chk("R12", "opcode 1111111", 32'(illegal), 32'd1);

    // R2
    run(enc_r(0, 7, 6, 0, 5, 7'h33), 32'h0, 32'd7, 32'd5);
    chk("R2", "add", rd_wdata, 32'd12);
    run(enc_r(32, 7, 6, 0, 5, 7'h33), 32'h0, 32'd5, 32'd7);
    chk("R2", "sub", rd_wdata, 32'hFFFF_FFFE);
    run(enc_r(32, 7, 6, 5, 5, 7'h33), 32'h0, 32'h8000_0000, 32'd33);
    chk("R2", "sra low 5 bits", rd_wdata, 32'hC000_0000);
    run(enc_r(0, 7, 6, 1, 5, 7'h33), 32'h0, 32'd1, 32'd63);
    chk("R2", "sll by 31", rd_wdata, 32'h8000_0000);

    // R3
    run(enc_i(1024, 1, 0, 3, 7'h13), 32'h0, 32'd1, 32'd0);
    chk("R3", "addi bit30 set", rd_wdata, 32'd1025);
    run(enc_i(1024 + 4, 1, 5, 3, 7'h13), 32'h0, 32'hF000_0000, 32'd0);
    chk("R3", "srai 4", rd_wdata, 32'hFF00_0000);
    run(enc_i(4, 1, 5, 3, 7'h13), 32'h0, 32'hF000_0000, 32'd0);
    chk("R3", "srli 4", rd_wdata, 32'h0F00_0000);
    run(enc_i(-1, 1, 4, 3, 7'h13), 32'h0, 32'h1234_5678, 32'd0);
    chk("R3", "xori -1", rd_wdata, 32'hEDCB_A987);

    // R4
    run(enc_r(0, 2, 1, 2, 4, 7'h33), 32'h0, 32'hFFFF_FFFF, 32'd1);
    chk("R4", "slt signed", rd_wdata, 32'd1);
    run(enc_r(0, 2, 1, 3, 4, 7'h33), 32'h0, 32'hFFFF_FFFF, 32'd1);
    chk("R4", "sltu unsigned", rd_wdata, 32'd0);
    run(enc_i(-1, 1, 3, 4, 7'h13), 32'h0, 32'd5, 32'd0);
    chk("R4", "sltiu vs all-ones", rd_wdata, 32'd1);

    // R5
    run({20'h12345, 5'd9, 7'h37}, 32'h0, 32'd0, 32'd0);
    chk("R5", "lui", rd_wdata, 32'h1234_5000);
    run({20'hFFFFF, 5'd9, 7'h17}, 32'h1000, 32'd0, 32'd0);
    chk("R5", "auipc wrap", rd_wdata, 32'h0000_0000);

    // R6
    run(enc_j(-8, 1), 32'h100, 32'd0, 32'd0);
    chk("R6", "jal back target", next_pc, 32'h0000_00F8);
    chk("R6", "jal link", rd_wdata, 32'h0000_0104);
    run(enc_j(32'h000F_FFFE, 1), 32'h0, 32'd0, 32'd0);
    chk("R6", "jal max forward", next_pc, 32'h000F_FFFE);

    // R7
    run(enc_i(2, 5, 0, 1, 7'h67), 32'h400, 32'h203, 32'd0);
    chk("R7", "jalr clears bit 0", next_pc, 32'h0000_0204);
    run(enc_i(-1, 5, 0, 1, 7'h67), 32'h400, 32'h10, 32'd0);
    chk("R7", "jalr negative unscaled", next_pc, 32'h0000_000E);

    // R8 / R9
    run(enc_b(-4096, 2, 1, 0), 32'h2000, 32'd9, 32'd9);
    chk("R8", "beq min offset", next_pc, 32'h0000_1000);
    run(enc_b(16, 2, 1, 1), 32'h2000, 32'd9, 32'd9);
    chk("R9", "bne not taken", next_pc, 32'h0000_2004);
    run(enc_b(2048, 2, 1, 4), 32'h2000, 32'hFFFF_FFFF, 32'd1);
    chk("R8", "blt signed taken", next_pc, 32'h0000_2800);
    run(enc_b(2048, 2, 1, 6), 32'h2000, 32'hFFFF_FFFF, 32'd1);
    chk("R9", "bltu not taken", next_pc, 32'h0000_2004);
    run(enc_b(8, 2, 1, 2), 32'h2000, 32'd0, 32'd0);
    chk("R9", "funct3 010 never taken", next_pc, 32'h0000_2004);

    // R10
    run(enc_i(-4, 1, 2, 7, 7'h03), 32'h0, 32'h1000, 32'd0);
    chk("R10", "load address", mem_addr, 32'h0000_0FFC);
    chk("R10", "load no write", 32'(rd_we), 32'd0);
    run(enc_s(-1, 2, 1, 2), 32'h0, 32'h1000, 32'hCAFE_F00D);
    chk("R10", "store address", mem_addr, 32'h0000_0FFF);
    chk("R10", "store data", store_data, 32'hCAFE_F00D);

    // R11
    run(enc_r(0, 7, 6, 0, 0, 7'h33), 32'h0, 32'd7, 32'd5);
    chk("R11", "add to x0", 32'(rd_we), 32'd0);
    run(enc_j(8, 0), 32'h0, 32'd0, 32'd0);
    chk("R11", "jal to x0 still jumps", next_pc, 32'h0000_0008);

    // random words over every opcode
    for (int n = 0; n < 4000; n++) begin
      logic [6:0] ops [10] = '{7'h37, 7'h17, 7'h6f, 7'h67, 7'h63, 7'h03, 7'h23, 7'h13, 7'h33, 7'h5b};
      logic [31:0] w = $urandom;
      logic [31:0] a = $urandom;
      logic [31:0] b = (n % 7 == 0) ? a : 32'($urandom);
      w[6:0] = ops[$urandom_range(0, 9)];
      run(w, {$urandom, 2'b00} & 32'hFFFF_FFFC, a, b);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule